// File: doc/BRIEF.md
# ATA PIO Register Transfer Host Engine

This block sits on the host side of a parallel ATA-style link and carries out one 8-bit register access at a time. A requester offers a transfer on a valid/ready port with the direction, a select pair, a 3-bit register index and, for writes, the byte to send. The engine then runs the pin sequence in the order address, strobe and recovery. It drives the active-low selects and the register index, pulses the read or write strobe, drives the data bus through a separate output enable, and returns the read byte with a one-cycle completion pulse.

All intervals come from a single clock-period parameter. Each nanosecond limit is divided by the period and rounded up to whole cycles. The active time and the minimum recovery time together fall short of the minimum strobe-to-strobe cycle, so the engine makes the recovery phase longer by the missing cycles. The recovery phase also covers the window in which the device may still drive the bus after a read, so the host never drives the bus against the device.

Back-pressure: `req_ready` is high only while the engine is idle. A transfer is taken on a clock edge where `req_valid` and `req_ready` are both high. Request fields are sampled only on that edge. The completion pulse cannot be stalled: a requester that needs the read byte must take it while `rsp_valid` is high, or later from `rsp_rdata`, which holds its value until the next read.

Top module: `ata_pio_host`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, both selects, `ata_rd_n` and `ata_wr_n` are high and `ata_dd_oe` is low.
- R2: `req_ready` is low from the cycle after acceptance until the transfer completes. Request inputs that change during that time have no effect on `ata_da` or `ata_cs_n`.
- R3: Selects and register index are driven for exactly ceil(25 ns / period) cycles before the strobe falls.
- R4: Exactly one strobe falls per transfer (`ata_rd_n` for reads, `ata_wr_n` for writes). It stays low for exactly ceil(70 ns / period) cycles.
- R5: From the strobe rise to `rsp_valid`, the engine waits max(ceil(25/p), ceil(30/p), ceil(120/p) − ceil(70/p), ceil(10/p)) cycles. Two successive strobe falls are never closer than ceil(120 ns / period) cycles.
- R6: Selects and register index stay driven for exactly ceil(10 ns / period) cycles after the strobe rises, then all selects go high.
- R7: On a write, `ata_dd_oe` is high and `ata_dd_o` equals the request byte from the first driven cycle until exactly ceil(10 ns / period) cycles after `ata_wr_n` rises.
- R8: On a read, `ata_dd_oe` stays low. `rsp_rdata` takes the value of `ata_dd_i` on the edge where `ata_rd_n` rises and keeps it through later writes.
- R9: `rsp_valid` is high for one cycle, the first cycle in which `req_ready` is high again. A request already waiting is taken on the next edge.
- R10: Select output bit i is low during a transfer exactly when request select bit i was 1 (bit 0 is the first select). `ata_da` carries the request register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_cs | input | 2 | Select pair, active high, bit 0 first select |
| req_addr | input | 3 | Register index |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| ata_cs_n | output | 2 | Active-low selects to device |
| ata_da | output | 3 | Register index to device |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dd_o | output | 8 | Data bus value driven by host |
| ata_dd_oe | output | 1 | Host data bus driver enable |
| ata_dd_i | input | 8 | Data bus value seen from device |

## Verification
The properties check, on every cycle, the idle pin state, that the two strobes are never low together, the exact strobe width, that the index does not change while selects are held, that the bus is not driven during a read, and that the completion pulse is one cycle long and lines up with ready. Only the bench scenarios can show the setup and hold counts, the stretched recovery, the spacing between strobes in back-to-back traffic, and data integrity through a device model across both selects. Data integrity covers write bytes landing in the right register and read bytes sampled at the strobe rise.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } ata_phase_e;

  // Interface limits in nanoseconds
  localparam int unsigned ADDR_SETUP_NS  = 25;
  localparam int unsigned STROBE_LOW_NS  = 70;
  localparam int unsigned STROBE_HIGH_NS = 25;
  localparam int unsigned FULL_CYCLE_NS  = 120;
  localparam int unsigned ADDR_HOLD_NS   = 10;
  localparam int unsigned WDATA_HOLD_NS  = 10;
  localparam int unsigned RD_RELEASE_NS  = 30;

  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ata_pio_timer.sv
module ata_pio_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          enable,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (restart)  count <= '0;
    else if (enable)   count <= count + 1'b1;
  end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int T_SU  = 1,
  parameter int T_ACT = 1,
  parameter int T_RCV = 1,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] count,
  output logic          req_ready,
  output logic          accept,
  output logic          capture,
  output logic          restart,
  output logic          tick_en,
  output logic          rsp_valid,
  output ata_phase_e    phase
);

  logic       last;
  ata_phase_e phase_nx;

  always_comb begin
    last = 1'b0;
    unique case (phase)
      PH_SETUP:   last = (count == CW'(T_SU - 1));
      PH_ACTIVE:  last = (count == CW'(T_ACT - 1));
      PH_RECOVER: last = (count == CW'(T_RCV - 1));
      default:    last = 1'b0;
    endcase
  end

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign restart   = accept || last;
  assign tick_en   = (phase != PH_IDLE);
  assign capture   = (phase == PH_ACTIVE) && last;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:    if (accept) phase_nx = PH_SETUP;
      PH_SETUP:   if (last)   phase_nx = PH_ACTIVE;
      PH_ACTIVE:  if (last)   phase_nx = PH_RECOVER;
      PH_RECOVER: if (last)   phase_nx = PH_IDLE;
      default:                phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      phase     <= phase_nx;
      rsp_valid <= (phase == PH_RECOVER) && last;
    end
  end

endmodule

// File: rtl/ata_pio_pins.sv
module ata_pio_pins
  import ata_pio_pkg::*;
#(
  parameter int NCS  = 2,
  parameter int AW   = 3,
  parameter int DW   = 8,
  parameter int T_AH = 1,
  parameter int T_WH = 1,
  parameter int CW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           capture,
  input  ata_phase_e     phase,
  input  logic [CW-1:0]  count,
  input  logic           req_write,
  input  logic [NCS-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NCS-1:0] ata_cs_n,
  output logic [AW-1:0]  ata_da,
  output logic           ata_rd_n,
  output logic           ata_wr_n,
  output logic [DW-1:0]  ata_dd_o,
  output logic           ata_dd_oe,
  input  logic [DW-1:0]  ata_dd_i
);

  logic           wr_q;
  logic [NCS-1:0] cs_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic           in_xfer;
  logic           addr_on;
  logic           data_on;
  logic           strobe_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      cs_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      cs_q    <= req_cs;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rsp_rdata <= '0;
    else if (capture && !wr_q)  rsp_rdata <= ata_dd_i;
  end

  assign in_xfer   = (phase == PH_SETUP) || (phase == PH_ACTIVE);
  assign addr_on   = in_xfer || ((phase == PH_RECOVER) && (count < CW'(T_AH)));
  assign data_on   = in_xfer || ((phase == PH_RECOVER) && (count < CW'(T_WH)));
  assign strobe_on = (phase == PH_ACTIVE);

  for (genvar g = 0; g < NCS; g++) begin : g_sel
    assign ata_cs_n[g] = ~(addr_on & cs_q[g]);
  end

  assign ata_da    = addr_q;
  assign ata_rd_n  = ~(strobe_on & ~wr_q);
  assign ata_wr_n  = ~(strobe_on & wr_q);
  assign ata_dd_o  = wdata_q;
  assign ata_dd_oe = wr_q & data_on;

endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
  import ata_pio_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int NCS           = 2,
  parameter int AW            = 3,
  parameter int DW            = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [NCS-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NCS-1:0] ata_cs_n,
  output logic [AW-1:0]  ata_da,
  output logic           ata_rd_n,
  output logic           ata_wr_n,
  output logic [DW-1:0]  ata_dd_o,
  output logic           ata_dd_oe,
  input  logic [DW-1:0]  ata_dd_i
);

  localparam int T_SU  = ns_to_cyc(ADDR_SETUP_NS,  CLK_PERIOD_NS);
  localparam int T_ACT = ns_to_cyc(STROBE_LOW_NS,  CLK_PERIOD_NS);
  localparam int T_REC = ns_to_cyc(STROBE_HIGH_NS, CLK_PERIOD_NS);
  localparam int T_CYC = ns_to_cyc(FULL_CYCLE_NS,  CLK_PERIOD_NS);
  localparam int T_AH  = ns_to_cyc(ADDR_HOLD_NS,   CLK_PERIOD_NS);
  localparam int T_WH  = ns_to_cyc(WDATA_HOLD_NS,  CLK_PERIOD_NS);
  localparam int T_REL = ns_to_cyc(RD_RELEASE_NS,  CLK_PERIOD_NS);
  localparam int T_RCV = imax(imax(T_REC, T_REL),
                              imax(T_CYC - T_ACT, imax(T_AH, T_WH)));
  localparam int T_MAX = imax(T_SU, imax(T_ACT, T_RCV));
  localparam int CW    = $clog2(T_MAX + 1);

  logic          accept;
  logic          capture;
  logic          restart;
  logic          tick_en;
  logic [CW-1:0] count;
  ata_phase_e    phase;

  ata_pio_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .enable  (tick_en),
    .count   (count)
  );

  ata_pio_seq #(
    .T_SU (T_SU),
    .T_ACT(T_ACT),
    .T_RCV(T_RCV),
    .CW   (CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .count    (count),
    .req_ready(req_ready),
    .accept   (accept),
    .capture  (capture),
    .restart  (restart),
    .tick_en  (tick_en),
    .rsp_valid(rsp_valid),
    .phase    (phase)
  );

  ata_pio_pins #(
    .NCS (NCS),
    .AW  (AW),
    .DW  (DW),
    .T_AH(T_AH),
    .T_WH(T_WH),
    .CW  (CW)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .capture  (capture),
    .phase    (phase),
    .count    (count),
    .req_write(req_write),
    .req_cs   (req_cs),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata),
    .ata_cs_n (ata_cs_n),
    .ata_da   (ata_da),
    .ata_rd_n (ata_rd_n),
    .ata_wr_n (ata_wr_n),
    .ata_dd_o (ata_dd_o),
    .ata_dd_oe(ata_dd_oe),
    .ata_dd_i (ata_dd_i)
  );

endmodule

// File: rtl/ata_pio_host_chk.sv
module ata_pio_host_chk
  import ata_pio_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int NCS           = 2,
  parameter int AW            = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic [NCS-1:0] ata_cs_n,
  input logic [AW-1:0]  ata_da,
  input logic           ata_rd_n,
  input logic           ata_wr_n,
  input logic           ata_dd_oe
);

  localparam int EXP_LOW = ns_to_cyc(STROBE_LOW_NS, CLK_PERIOD_NS);
  localparam logic [NCS-1:0] ALL_OFF = '1;

  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    low_cnt <= '0;
    else if (!ata_rd_n || !ata_wr_n) low_cnt <= low_cnt + 16'd1;
    else                           low_cnt <= '0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ata_cs_n == ALL_OFF && ata_rd_n && ata_wr_n && !ata_dd_oe));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));

  a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    (ata_rd_n && ata_wr_n && low_cnt != 16'd0) |-> (low_cnt == 16'(EXP_LOW)));

  a_r2_index_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ata_cs_n != ALL_OFF && $past(ata_cs_n) != ALL_OFF) |-> $stable(ata_da));

  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_rd_n |-> !ata_dd_oe);

  a_r7_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_wr_n |-> ata_dd_oe);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

endmodule

bind ata_pio_host ata_pio_host_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .NCS          (NCS),
  .AW           (AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .ata_cs_n (ata_cs_n),
  .ata_da   (ata_da),
  .ata_rd_n (ata_rd_n),
  .ata_wr_n (ata_wr_n),
  .ata_dd_oe(ata_dd_oe)
);

// File: tb/test_ata_pio_host.sv
module test_ata_pio_host;

  localparam int P = 4;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_SU  = cdiv(25, P);
  localparam int E_ACT = cdiv(70, P);
  localparam int E_AH  = cdiv(10, P);
  localparam int E_WH  = cdiv(10, P);
  localparam int E_CYC = cdiv(120, P);
  localparam int E_RCV = mx(mx(cdiv(25, P), cdiv(30, P)), mx(E_CYC - E_ACT, E_AH));

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [1:0] req_cs = 2'b00;
  logic [2:0] req_addr = 3'd0;
  logic [7:0] req_wdata = 8'd0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic [1:0] ata_cs_n;
  logic [2:0] ata_da;
  logic       ata_rd_n, ata_wr_n, ata_dd_oe;
  logic [7:0] ata_dd_o, ata_dd_i;

  always #2 clk = ~clk;

  ata_pio_host #(.CLK_PERIOD_NS(P)) i_ata_pio_host (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ata_cs_n(ata_cs_n), .ata_da(ata_da), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
    .ata_dd_o(ata_dd_o), .ata_dd_oe(ata_dd_oe), .ata_dd_i(ata_dd_i)
  );

  // Device model: bank 1 when second select low, else bank 0
  logic [7:0] dev_mem [0:15];
  logic [7:0] exp_mem [0:15];
  logic [3:0] dev_idx;
  assign dev_idx  = {~ata_cs_n[1], ata_da};
  assign ata_dd_i = !ata_rd_n ? dev_mem[dev_idx] : 8'hEE;
  always @(posedge ata_wr_n) if (ata_dd_oe) dev_mem[dev_idx] = ata_dd_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Monitor
  int cyc = 0, mph = 0, su, act, ah, wh, rc, last_fall = -1;
  logic [1:0] m_cs; logic [2:0] m_da; bit m_wr; logic [7:0] m_wd;
  bit bad_hold, bad_oe, prev_rsp;
  bit cur_wr; logic [1:0] cur_cs; logic [2:0] cur_addr; logic [7:0] cur_wd;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_rsp) chk(!rsp_valid, "R9 pulse", rsp_valid, 0);
      prev_rsp = rsp_valid;
      case (mph)
        0: if (ata_cs_n != 2'b11) begin
             mph = 1; su = 1; m_cs = ata_cs_n; m_da = ata_da;
             m_wr = cur_wr; m_wd = cur_wd; bad_hold = 0; bad_oe = 0;
             chk(ata_cs_n == ~cur_cs && ata_da == cur_addr, "R10", {ata_cs_n, ata_da}, {~cur_cs, cur_addr});
           end
        1: begin
             if (ata_da != m_da || ata_cs_n != m_cs) bad_hold = 1;
             if (m_wr ? (!ata_dd_oe || ata_dd_o != m_wd) : ata_dd_oe) bad_oe = 1;
             if (!ata_rd_n || !ata_wr_n) begin
               chk(su == E_SU, "R3", su, E_SU);
               chk(m_wr ? (!ata_wr_n && ata_rd_n) : (!ata_rd_n && ata_wr_n), "R4 strobe",
                   {ata_rd_n, ata_wr_n}, m_wr ? 2 : 1);
               if (last_fall >= 0) chk(cyc - last_fall >= E_CYC, "R5 spacing", cyc - last_fall, E_CYC);
               last_fall = cyc; mph = 2; act = 1;
             end else su++;
           end
        2: begin
             if (m_wr ? (!ata_dd_oe || ata_dd_o != m_wd) : ata_dd_oe) bad_oe = 1;
             if (!ata_rd_n || !ata_wr_n) begin
               act++;
               if (ata_da != m_da || ata_cs_n != m_cs) bad_hold = 1;
             end else begin
               chk(act == E_ACT, "R4 width", act, E_ACT);
               mph = 3; rc = 1;
               ah = (ata_cs_n != 2'b11) ? 1 : 0;
               wh = ata_dd_oe ? 1 : 0;
             end
           end
        default: begin
             if (rsp_valid) begin
               chk(rc == E_RCV, "R5 recovery", rc, E_RCV);
               chk(ah == E_AH, "R6", ah, E_AH);
               chk(!bad_hold, "R2 stable", bad_hold, 0);
               if (m_wr) begin
                 chk(wh == E_WH, "R7 hold", wh, E_WH);
                 chk(!bad_oe, "R7 drive", bad_oe, 0);
               end else chk(!bad_oe && wh == 0, "R8 no drive", wh, 0);
               chk(req_ready, "R9 ready", req_ready, 1);
               mph = 0;
             end else begin
               rc++;
               if (ata_cs_n != 2'b11) ah++;
               if (ata_dd_oe) wh++;
             end
           end
      endcase
    end
  end

  logic [7:0] last_rd = 8'd0;

  task automatic xfer(input bit wr, input logic [1:0] cs, input logic [2:0] ad, input logic [7:0] d);
    int idx;
    while (!req_ready) @(negedge clk);
    cur_wr = wr; cur_cs = cs; cur_addr = ad; cur_wd = d;
    req_valid = 1; req_write = wr; req_cs = cs; req_addr = ad; req_wdata = d;
    @(negedge clk);
    chk(!req_ready, "R2 busy", req_ready, 0);
    req_valid = 0; req_write = $urandom % 2; req_cs = 2'($urandom);
    req_addr = 3'($urandom); req_wdata = 8'($urandom);
    while (!rsp_valid) @(negedge clk);
    idx = {cs[1], ad};
    if (wr) begin
      exp_mem[idx] = d;
      chk(rsp_rdata == last_rd, "R8 keep", rsp_rdata, last_rd);
    end else begin
      chk(rsp_rdata == exp_mem[idx], "R8 data", rsp_rdata, exp_mem[idx]);
      last_rd = exp_mem[idx];
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      dev_mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !ata_dd_oe, "R1 in reset",
        {ata_cs_n, ata_rd_n, ata_wr_n, ata_dd_oe}, 5'b11110);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && ata_cs_n == 2'b11 && !ata_dd_oe, "R1 after reset", req_ready, 1);
    // Directed: both selects, extreme values, back-to-back
    xfer(1'b0, 2'b01, 3'd0, 8'h00);
    xfer(1'b1, 2'b01, 3'd7, 8'hFF);
    xfer(1'b1, 2'b10, 3'd7, 8'h00);
    xfer(1'b0, 2'b01, 3'd7, 8'h00);
    xfer(1'b0, 2'b10, 3'd7, 8'h00);
    xfer(1'b1, 2'b10, 3'd3, 8'hA5);
    xfer(1'b0, 2'b10, 3'd3, 8'h00);
    // Random traffic with idle gaps
    for (int n = 0; n < 60; n++) begin
      bit w = 1'($urandom);
      logic [1:0] c = ($urandom % 2) ? 2'b10 : 2'b01;
      xfer(w, c, 3'($urandom), 8'($urandom));
      if ($urandom % 3 == 0) repeat ($urandom % 5 + 1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(req_ready && ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !ata_dd_oe, "R1 idle end",
        req_ready, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule